// File: doc/BRIEF.md
# Transparent Serial Link Transmitter

This block takes bytes that a host writes into an internal FIFO and sends them out on a one-bit link output. It sends one bit for each link clock enable pulse. The link is transparent: each byte leaves exactly as it was written, least significant bit first. The block adds no flags, does no bit stuffing and computes no check sequence. When the FIFO has nothing to send at a byte boundary, the block fills the link. It sends either a byte of all ones or a programmable idle byte, chosen by the idle-select control.

The host sets a free-space threshold. The block reports reaching it in two ways: a live status bit that follows the FIFO fill level, and a latched interrupt flag. A separate flag marks the moment the FIFO drains completely, which is the end of a transmission. A third flag records writes that were dropped because the FIFO was full. The host clears flags by writing ones to them. A mask folds the flags into a single interrupt line.

A synchronous transmitter reset empties the FIFO and returns the serializer to its byte boundary. The host should apply it whenever the operating mode is changed.

Top module: `tlink_tx`

## Requirements
- R1: While `tx_en` is 1, each cycle with `bit_en` high moves one bit onto `ser_out`. The new bit appears on the clock edge that samples `bit_en`, and each byte is sent least significant bit first with no alteration.
- R2: While `tx_en` is 0, `ser_out` is 1 and the serializer stays at a byte boundary. The first `bit_en` after enable starts a fresh byte, so a byte interrupted by disabling is abandoned.
- R3: At a byte boundary with an empty FIFO, the byte sent is 8'hFF when `idle_sel` is 0. When `idle_sel` is 1 it is `idle_byte`, sampled at that boundary.
- R4: `lvl_live` is 1 exactly when `free_cnt` is less than or equal to `empty_lvl`. It drops as soon as free space rises above the threshold.
- R5: `irq_flags[1]` (level flag) sets when `lvl_live` goes from 0 to 1. It stays set until cleared, even after `lvl_live` falls.
- R6: `irq_flags[0]` (done flag) sets when a byte is taken from the FIFO and leaves it empty.
- R7: The FIFO holds 64 bytes, and `free_cnt` gives the number of free locations. A write to a full FIFO is dropped and sets `irq_flags[2]` (overflow flag).
- R8: A 1 on bit n of `irq_clr` clears flag n. A new set in the same cycle takes priority. `irq` is the OR over n of `irq_flags[n] & irq_en[n]`.
- R9: `tx_rst` empties the FIFO (`free_cnt` returns to 64), clears all flags and returns `ser_out` to 1.
- R10: Bytes leave the FIFO in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_rst | input | 1 | Synchronous transmitter reset |
| tx_en | input | 1 | Transmitter enable |
| bit_en | input | 1 | Link clock enable, one bit per pulse |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| idle_sel | input | 1 | 0: idle sends ones, 1: idle sends `idle_byte` |
| idle_byte | input | 8 | Programmable idle byte |
| empty_lvl | input | 6 | Free-space threshold |
| irq_en | input | 3 | Interrupt mask per flag |
| irq_clr | input | 3 | Write-one-to-clear per flag |
| ser_out | output | 1 | Serial link data |
| free_cnt | output | 7 | Free FIFO locations |
| lvl_live | output | 1 | Live threshold status |
| irq_flags | output | 3 | Flags: [0] done, [1] level, [2] overflow |
| irq | output | 1 | Combined masked interrupt |

## Verification
On every cycle, the assertions check the following:
- the FIFO occupancy bound and the single-step count changes;
- the bit counter stepping down between byte boundaries, and the idle-high output while disabled;
- flags holding until they are cleared;
- the done flag rising only with an empty FIFO;
- the level flag following a rise of `lvl_live`;
- a dropped write raising the overflow flag.

The bench scenarios cover what needs a known bit stream:
- the exact bit order of written bytes;
- the choice between ones and the idle byte;
- the byte realignment after a mid-byte disable;
- the masking of the interrupt line;
- the full clearing effect of the transmitter reset.

// File: rtl/tlink_pkg.sv
package tlink_pkg;
   localparam int FLG_DONE = 0;
   localparam int FLG_LVL  = 1;
   localparam int FLG_OVF  = 2;
   localparam int NFLAG    = 3;
endpackage

// File: rtl/tlink_fifo.sv
module tlink_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count,
   output logic              dropped,
   output logic              drained
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign push_ok = push_req && !full;
   assign pop_ok  = pop && !empty;
   assign dropped = push_req && full;
   assign drained = pop_ok && !push_ok && (count == CNT_W'(1));
   assign rd_data = mem[rd_ptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         if (push_ok && !pop_ok)      count <= count + 1'b1;
         else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && full && !pop && !clr |=> full);
   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (count == $past(count)) || (count == $past(count) + 1'b1)
               || (count == $past(count) - 1'b1));
endmodule

// File: rtl/tlink_ser.sv
module tlink_ser #(
   parameter int DATA_W = 8,
   localparam int BC_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_rst,
   input  logic              tx_en,
   input  logic              bit_en,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              idle_sel,
   input  logic [DATA_W-1:0] idle_byte,
   output logic              pop,
   output logic              ser_out
);
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] nxt;
   logic [BC_W-1:0]   bcnt;
   logic              run, boundary;

   assign run      = tx_en && !tx_rst;
   assign boundary = (bcnt == '0);
   assign pop      = run && bit_en && boundary && !fifo_empty;

   always_comb begin
      if (!fifo_empty)   nxt = fifo_data;
      else if (idle_sel) nxt = idle_byte;
      else               nxt = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_out <= 1'b1;
         sh      <= '1;
         bcnt    <= '0;
      end else if (!run) begin
         ser_out <= 1'b1;
         sh      <= '1;
         bcnt    <= '0;
      end else if (bit_en) begin
         if (boundary) begin
            ser_out <= nxt[0];
            sh      <= nxt >> 1;
            bcnt    <= BC_W'(DATA_W - 1);
         end else begin
            ser_out <= sh[0];
            sh      <= sh >> 1;
            bcnt    <= bcnt - 1'b1;
         end
      end
   end

   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> ser_out);
   assert_bit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run && bit_en && !boundary |=> bcnt == $past(bcnt) - 1'b1);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run && !bit_en |=> $stable(ser_out));
endmodule

// File: rtl/tlink_irq.sv
module tlink_irq #(
   parameter int NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_all,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   input  logic [NF-1:0] en,
   output logic [NF-1:0] flags,
   output logic          irq
);
   genvar i;
   generate
      for (i = 0; i < NF; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (clr_all)  flags[i] <= 1'b0;
            else if (set[i])   flags[i] <= 1'b1;
            else if (clr[i])   flags[i] <= 1'b0;
         end
         assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !clr[i] && !clr_all |=> flags[i]);
         assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] && !clr_all |=> flags[i]);
      end
   endgenerate

   assign irq = |(flags & en);
endmodule

// File: rtl/tlink_tx.sv
module tlink_tx #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int LVL_W  = 6,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int NF    = tlink_pkg::NFLAG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_rst,
   input  logic              tx_en,
   input  logic              bit_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              idle_sel,
   input  logic [DATA_W-1:0] idle_byte,
   input  logic [LVL_W-1:0]  empty_lvl,
   input  logic [NF-1:0]     irq_en,
   input  logic [NF-1:0]     irq_clr,
   output logic              ser_out,
   output logic [CNT_W-1:0]  free_cnt,
   output logic              lvl_live,
   output logic [NF-1:0]     irq_flags,
   output logic              irq
);
   import tlink_pkg::*;

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must be at least 2");
      assert (DEPTH >= 2)  else $error("DEPTH must be at least 2");
      assert (LVL_W <= CNT_W) else $error("LVL_W wider than free count");
   end

   logic [DATA_W-1:0] fifo_data;
   logic              fifo_empty, fifo_full, pop, dropped, drained, lvl_q;
   logic [CNT_W-1:0]  count;
   logic [NF-1:0]     set;

   tlink_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(tx_rst),
      .push_req(wr_valid), .wr_data(wr_data),
      .pop(pop), .rd_data(fifo_data),
      .empty(fifo_empty), .full(fifo_full), .count(count),
      .dropped(dropped), .drained(drained)
   );

   tlink_ser #(.DATA_W(DATA_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .tx_en(tx_en),
      .bit_en(bit_en), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
      .idle_sel(idle_sel), .idle_byte(idle_byte),
      .pop(pop), .ser_out(ser_out)
   );

   assign free_cnt = CNT_W'(DEPTH) - count;
   assign lvl_live = int'(free_cnt) <= int'(empty_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= 1'b0;
      else if (tx_rst) lvl_q <= 1'b0;
      else             lvl_q <= lvl_live;
   end

   always_comb begin
      set           = '0;
      set[FLG_DONE] = drained;
      set[FLG_LVL]  = lvl_live && !lvl_q;
      set[FLG_OVF]  = dropped;
   end

   tlink_irq #(.NF(NF)) u_irq (
      .clk(clk), .rst_n(rst_n), .clr_all(tx_rst),
      .set(set), .clr(irq_clr), .en(irq_en),
      .flags(irq_flags), .irq(irq)
   );

   assert_done_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[FLG_DONE]) |-> fifo_empty);
   assert_lvl_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_live) && !tx_rst |=> irq_flags[FLG_LVL]);
   assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && fifo_full && !tx_rst |=> irq_flags[FLG_OVF]);
   assert_rst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |=> (irq_flags == '0) && (free_cnt == CNT_W'(DEPTH)));
endmodule

// File: tb/tlink_tx_bench.sv
module tlink_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_rst = 1'b0, tx_en = 1'b0, bit_en = 1'b0, wr_valid = 1'b0;
   logic [7:0] wr_data = '0, idle_byte = '0;
   logic       idle_sel = 1'b0;
   logic [5:0] empty_lvl = '0;
   logic [2:0] irq_en = '0, irq_clr = '0;
   logic       ser_out, lvl_live, irq;
   logic [6:0] free_cnt;
   logic [2:0] irq_flags;

   int checks = 0, errors = 0, cycles = 0;
   logic exp_q[$];
   logic be_d = 1'b0;

   always #10 clk = ~clk;

   tlink_tx u_tlink_tx (
      .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .tx_en(tx_en), .bit_en(bit_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .idle_sel(idle_sel),
      .idle_byte(idle_byte), .empty_lvl(empty_lvl), .irq_en(irq_en),
      .irq_clr(irq_clr), .ser_out(ser_out), .free_cnt(free_cnt),
      .lvl_live(lvl_live), .irq_flags(irq_flags), .irq(irq)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // scoreboard monitor: one expected bit per observed link enable
   always @(posedge clk) be_d <= bit_en;
   always @(negedge clk) begin
      cycles++;
      if (be_d) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 bit with empty scoreboard actual=%0d expected=none", ser_out);
         end else begin
            logic e;
            e = exp_q.pop_front();
            if (ser_out !== e) begin
               errors++;
               $display("FAIL R1 serial bit actual=%0d expected=%0d", ser_out, e);
            end
         end
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         finish_run();
      end
   end

   task automatic expect_byte(logic [7:0] b);
      for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
   endtask

   task automatic run_bits(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_en = 1'b1;
         @(negedge clk) bit_en = 1'b0;
      end
   endtask

   task automatic write_byte(logic [7:0] b);
      @(negedge clk) begin wr_valid = 1'b1; wr_data = b; end
      @(negedge clk) wr_valid = 1'b0;
   endtask

   task automatic pulse_clr(logic [2:0] m);
      @(negedge clk) irq_clr = m;
      @(negedge clk) irq_clr = '0;
   endtask

   task automatic pulse_rst();
      @(negedge clk) tx_rst = 1'b1;
      @(negedge clk) tx_rst = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      // reset state (R9 values after reset)
      check("R2 reset ser_out", ser_out, 1);
      check("R7 reset free_cnt", free_cnt, 64);
      check("R4 reset lvl_live", lvl_live, 0);
      check("R8 reset flags", irq_flags, 0);

      // R3: idle ones, aligned from first enable (R2)
      tx_en = 1'b1;
      expect_byte(8'hFF);
      run_bits(8);
      // R3: programmable idle byte
      idle_sel = 1'b1; idle_byte = 8'hA5;
      expect_byte(8'hA5);
      run_bits(8);

      // R1, R10: data LSB first, in order; R6 done flag
      write_byte(8'h3C);
      write_byte(8'h81);
      check("R7 free after two writes", free_cnt, 62);
      expect_byte(8'h3C);
      expect_byte(8'h81);
      run_bits(16);
      wait_cyc(1);
      check("R6 done flag set", irq_flags[0], 1);
      pulse_clr(3'b001);
      check("R8 done flag cleared", irq_flags[0], 0);

      // R4, R5: threshold live bit and latched flag
      empty_lvl = 6'd61; irq_en = 3'b010;
      write_byte(8'h11);
      write_byte(8'h22);
      wait_cyc(1);
      check("R4 live above threshold", lvl_live, 0);
      write_byte(8'h33);
      wait_cyc(1);
      check("R4 live at threshold", lvl_live, 1);
      check("R5 level flag set", irq_flags[1], 1);
      check("R8 irq enabled flag", irq, 1);
      expect_byte(8'h11);
      run_bits(8);
      check("R4 live drops", lvl_live, 0);
      check("R5 level flag sticky", irq_flags[1], 1);
      pulse_clr(3'b010);
      check("R5 level flag cleared", irq_flags[1], 0);
      expect_byte(8'h22);
      expect_byte(8'h33);
      run_bits(16);
      wait_cyc(1);
      check("R6 done flag again", irq_flags[0], 1);
      check("R8 masked flag no irq", irq, 0);

      // R2: disable mid-byte abandons it
      tx_en = 1'b0;
      wait_cyc(2);
      check("R2 disabled ser_out high", ser_out, 1);
      pulse_rst();
      write_byte(8'h0F);
      write_byte(8'hF0);
      @(negedge clk) tx_en = 1'b1;
      exp_q.push_back(1'b1); exp_q.push_back(1'b1); exp_q.push_back(1'b1);
      run_bits(3);
      @(negedge clk) tx_en = 1'b0;
      wait_cyc(2);
      check("R2 high after mid-byte disable", ser_out, 1);
      @(negedge clk) tx_en = 1'b1;
      expect_byte(8'hF0);
      run_bits(8);

      // R7: fill, overflow drop, order preserved
      @(negedge clk) tx_en = 1'b0;
      pulse_rst();
      empty_lvl = 6'd0; irq_en = 3'b100;
      for (int i = 0; i < 64; i++) write_byte(8'(i * 3));
      wait_cyc(1);
      check("R7 full free_cnt", free_cnt, 0);
      check("R7 no overflow yet", irq_flags[2], 0);
      write_byte(8'hEE);
      wait_cyc(1);
      check("R7 overflow flag", irq_flags[2], 1);
      check("R7 free still zero", free_cnt, 0);
      check("R8 overflow irq", irq, 1);
      @(negedge clk) tx_en = 1'b1;
      expect_byte(8'h00); expect_byte(8'h03); expect_byte(8'h06);
      run_bits(24);
      check("R10 free after three sent", free_cnt, 3);
      @(negedge clk) tx_en = 1'b0;

      // R9: transmitter reset
      pulse_rst();
      check("R9 free restored", free_cnt, 64);
      check("R9 flags cleared", irq_flags, 0);
      check("R9 ser_out high", ser_out, 1);
      idle_sel = 1'b0;
      @(negedge clk) tx_en = 1'b1;
      expect_byte(8'hFF);
      run_bits(8);
      wait_cyc(2);
      check("R1 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule